// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a processor byte address into a single chip select for one of seven address regions: four code-memory blocks, one scratch RAM, an internal I/O region and a peripheral I/O region. Each region has an enable, a base address and a window size given as a power of two. A window covers the naturally aligned span of that size around its base. The code-memory physical block size is chosen by a mode input as 8, 16 or 32 KB per block. A bus-width input selects byte or 16-bit word offsets.

The RAM and the two I/O regions may sit on top of code memory. There they win by fixed priority, so the code locations underneath cannot be reached. The decoder also checks the configuration while it is loaded. A code window that overlaps another code window, a RAM or I/O window that overlaps another RAM or I/O window, a code window larger than its physical block, or a reserved mode value raises a sticky error flag. The selects and the offset depend combinationally on the address. All configuration inputs are captured on each rising clock edge.

Top module: `memsel_decoder`

## Requirements
- R1: An enabled region matches an address when the address lies in the window of 2^lsz bytes aligned down from the region base. An lsz of ADDR_W or more covers the whole address space.
- R2: blk_mode_i encodes the code block size: 0 is 8 KB, 1 is 16 KB and 2 is 32 KB. Value 3 is reserved. It sets the error flag and decodes as 32 KB.
- R3: Selection priority is RAM, then internal I/O, then peripheral I/O, then code blocks 0 to 3 in index order. A code select is suppressed wherever a higher-priority region matches.
- R4: At most one select is high at any time. unmapped_o is high exactly when no select is high.
- R5: offset_o is the address modulo the region window size. For code blocks the modulus is the smaller of the window and the physical block. With bus16_i set, the offset is halved to a 16-bit word offset. offset_o is 0 when the address is unmapped.
- R6: Two enabled code windows that share any address set the error flag.
- R7: Two enabled windows among RAM, internal I/O and peripheral I/O that share any address set the error flag.
- R8: An enabled code window larger than the physical block size sets the error flag.
- R9: After reset, all regions are disabled, byte mode is active, and the error flag is low. Once set, the error flag stays high until reset, even if the configuration is corrected.
- R10: Configuration inputs take effect at the next rising clock edge, and the error flag for that configuration appears at the same edge. Address changes act without a clock.
- R11: A disabled region never selects and takes part in no error rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Processor byte address |
| bus16_i | input | 1 | 1 selects 16-bit word offsets |
| blk_mode_i | input | 2 | Code block size mode |
| code_en_i | input | 4 | Code window enables |
| code_base_i | input | 4*ADDR_W | Code window bases, block 0 in the low bits |
| code_lsz_i | input | 4*SZ_W | Code window log2 sizes |
| ram_en_i | input | 1 | RAM window enable |
| ram_base_i | input | ADDR_W | RAM window base |
| ram_lsz_i | input | SZ_W | RAM window log2 size |
| iio_en_i | input | 1 | Internal I/O window enable |
| iio_base_i | input | ADDR_W | Internal I/O window base |
| iio_lsz_i | input | SZ_W | Internal I/O window log2 size |
| pio_en_i | input | 1 | Peripheral I/O window enable |
| pio_base_i | input | ADDR_W | Peripheral I/O window base |
| pio_lsz_i | input | SZ_W | Peripheral I/O window log2 size |
| code_cs_o | output | 4 | Code block selects |
| ram_cs_o | output | 1 | RAM select |
| iio_cs_o | output | 1 | Internal I/O select |
| pio_cs_o | output | 1 | Peripheral I/O select |
| unmapped_o | output | 1 | No region selected |
| offset_o | output | ADDR_W | Offset within the selected region |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
On every cycle, the assertions check that the selects are one-hot or empty and agree with unmapped_o. They also check that an unmapped address gives a zero offset, that word mode clears the top offset bit, and that the error flag never drops. They also confirm that a reserved mode or a RAM window stacked on the internal I/O window raises the flag one edge later. Only the bench's scenarios can show the correct region and offset for each address. It sweeps the full address space under several layouts, including layouts where RAM and I/O sit inside code blocks and a code window is narrower than its block. The scenarios also cover the one-edge delay of configuration, each individual error rule, and the fact that disabled regions are ignored.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;
  typedef enum logic [1:0] {
    BLK_8K  = 2'd0,
    BLK_16K = 2'd1,
    BLK_32K = 2'd2,
    BLK_RSV = 2'd3
  } blk_mode_e;

  localparam int N_CODE  = 4;
  localparam int IDX_RAM = 4;
  localparam int IDX_IIO = 5;
  localparam int IDX_PIO = 6;
  localparam int N_REG   = 7;
endpackage

// File: rtl/memsel_win.sv
`timescale 1ns/1ps
// Aligned power-of-two window match and in-window byte offset.
module memsel_win #(
  parameter int ADDR_W = 17,
  parameter int SZ_W   = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SZ_W-1:0]   lsz_i,
  input  logic [SZ_W-1:0]   cap_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);
  logic [SZ_W-1:0]   eff_lsz;
  logic [ADDR_W-1:0] keep_m;
  logic [ADDR_W-1:0] low_m;

  assign eff_lsz = (lsz_i < cap_i) ? lsz_i : cap_i;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      keep_m[i] = (SZ_W'(i) >= lsz_i);
      low_m[i]  = (SZ_W'(i) < eff_lsz);
    end
  end

  assign hit_o = en_i && (((addr_i ^ base_i) & keep_m) == '0);
  assign off_o = addr_i & low_m;
endmodule

// File: rtl/memsel_cfg_chk.sv
`timescale 1ns/1ps
// Rule check on the incoming configuration.
module memsel_cfg_chk
  import memsel_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SZ_W        = 5,
  parameter int BLK_LSZ_MIN = 13
) (
  input  logic [N_REG-1:0]             en_i,
  input  logic [N_REG-1:0][ADDR_W-1:0] base_i,
  input  logic [N_REG-1:0][SZ_W-1:0]   lsz_i,
  input  blk_mode_e                    mode_i,
  output logic                         viol_o
);
  logic [SZ_W-1:0] blk_lsz;

  assign blk_lsz = SZ_W'(BLK_LSZ_MIN) + ((mode_i == BLK_RSV) ? SZ_W'(2) : SZ_W'(mode_i));

  function automatic logic clash(input logic ea, input logic eb,
                                 input logic [ADDR_W-1:0] ba, input logic [ADDR_W-1:0] bb,
                                 input logic [SZ_W-1:0] la, input logic [SZ_W-1:0] lb);
    logic [SZ_W-1:0]   big;
    logic [ADDR_W-1:0] keep;
    big = (la > lb) ? la : lb;
    for (int i = 0; i < ADDR_W; i++) keep[i] = (SZ_W'(i) >= big);
    return ea && eb && (((ba ^ bb) & keep) == '0);
  endfunction

  logic code_ovl, io_ovl, too_big;

  always_comb begin
    code_ovl = 1'b0;
    io_ovl   = 1'b0;
    too_big  = 1'b0;
    for (int a = 0; a < N_CODE; a++) begin
      for (int b = a + 1; b < N_CODE; b++)
        code_ovl |= clash(en_i[a], en_i[b], base_i[a], base_i[b], lsz_i[a], lsz_i[b]);
      too_big |= en_i[a] && (lsz_i[a] > blk_lsz);
    end
    for (int a = IDX_RAM; a < N_REG; a++)
      for (int b = a + 1; b < N_REG; b++)
        io_ovl |= clash(en_i[a], en_i[b], base_i[a], base_i[b], lsz_i[a], lsz_i[b]);
  end

  assign viol_o = code_ovl || io_ovl || too_big || (mode_i == BLK_RSV);
endmodule

// File: rtl/memsel_prio.sv
`timescale 1ns/1ps
// Fixed-priority resolve: RAM, IIO, PIO, then code 0..3.
module memsel_prio
  import memsel_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [N_REG-1:0]             hit_i,
  input  logic [N_REG-1:0][ADDR_W-1:0] off_i,
  output logic [N_REG-1:0]             sel_o,
  output logic                         none_o,
  output logic [ADDR_W-1:0]            off_o
);
  always_comb begin
    logic taken;
    sel_o = '0;
    taken = 1'b0;
    for (int r = IDX_RAM; r < N_REG; r++) begin
      if (hit_i[r] && !taken) begin
        sel_o[r] = 1'b1;
        taken    = 1'b1;
      end
    end
    for (int c = 0; c < N_CODE; c++) begin
      if (hit_i[c] && !taken) begin
        sel_o[c] = 1'b1;
        taken    = 1'b1;
      end
    end
    none_o = !taken;
  end

  always_comb begin
    off_o = '0;
    for (int r = 0; r < N_REG; r++) off_o |= off_i[r] & {ADDR_W{sel_o[r]}};
  end
endmodule

// File: rtl/memsel_decoder.sv
`timescale 1ns/1ps
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SZ_W        = 5,
  parameter int BLK_LSZ_MIN = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     bus16_i,
  input  logic [1:0]               blk_mode_i,
  input  logic [N_CODE-1:0]        code_en_i,
  input  logic [N_CODE*ADDR_W-1:0] code_base_i,
  input  logic [N_CODE*SZ_W-1:0]   code_lsz_i,
  input  logic                     ram_en_i,
  input  logic [ADDR_W-1:0]        ram_base_i,
  input  logic [SZ_W-1:0]          ram_lsz_i,
  input  logic                     iio_en_i,
  input  logic [ADDR_W-1:0]        iio_base_i,
  input  logic [SZ_W-1:0]          iio_lsz_i,
  input  logic                     pio_en_i,
  input  logic [ADDR_W-1:0]        pio_base_i,
  input  logic [SZ_W-1:0]          pio_lsz_i,
  output logic [N_CODE-1:0]        code_cs_o,
  output logic                     ram_cs_o,
  output logic                     iio_cs_o,
  output logic                     pio_cs_o,
  output logic                     unmapped_o,
  output logic [ADDR_W-1:0]        offset_o,
  output logic                     cfg_err_o
);
  // Incoming configuration, region-indexed.
  logic [N_REG-1:0]             en_d;
  logic [N_REG-1:0][ADDR_W-1:0] base_d;
  logic [N_REG-1:0][SZ_W-1:0]   lsz_d;
  blk_mode_e                    mode_d;

  always_comb begin
    for (int c = 0; c < N_CODE; c++) begin
      en_d[c]   = code_en_i[c];
      base_d[c] = code_base_i[c*ADDR_W +: ADDR_W];
      lsz_d[c]  = code_lsz_i[c*SZ_W +: SZ_W];
    end
    en_d[IDX_RAM] = ram_en_i;  base_d[IDX_RAM] = ram_base_i;  lsz_d[IDX_RAM] = ram_lsz_i;
    en_d[IDX_IIO] = iio_en_i;  base_d[IDX_IIO] = iio_base_i;  lsz_d[IDX_IIO] = iio_lsz_i;
    en_d[IDX_PIO] = pio_en_i;  base_d[IDX_PIO] = pio_base_i;  lsz_d[IDX_PIO] = pio_lsz_i;
  end

  assign mode_d = blk_mode_e'(blk_mode_i);

  logic viol;

  memsel_cfg_chk #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .BLK_LSZ_MIN(BLK_LSZ_MIN)
  ) u_cfg_chk (
    .en_i(en_d), .base_i(base_d), .lsz_i(lsz_d), .mode_i(mode_d), .viol_o(viol)
  );

  // Registered configuration.
  logic [N_REG-1:0]             en_q;
  logic [N_REG-1:0][ADDR_W-1:0] base_q;
  logic [N_REG-1:0][SZ_W-1:0]   lsz_q;
  blk_mode_e                    mode_q;
  logic                         bus16_q;
  logic                         err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      base_q  <= '0;
      lsz_q   <= '0;
      mode_q  <= BLK_8K;
      bus16_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      base_q  <= base_d;
      lsz_q   <= lsz_d;
      mode_q  <= mode_d;
      bus16_q <= bus16_i;
      err_q   <= err_q | viol;
    end
  end

  logic [SZ_W-1:0] blk_lsz_q;
  assign blk_lsz_q = SZ_W'(BLK_LSZ_MIN) + ((mode_q == BLK_RSV) ? SZ_W'(2) : SZ_W'(mode_q));

  logic [N_REG-1:0]             hit;
  logic [N_REG-1:0][ADDR_W-1:0] off_r;

  for (genvar g = 0; g < N_REG; g++) begin : g_win
    logic [SZ_W-1:0] cap;
    if (g < N_CODE) begin : g_code
      assign cap = blk_lsz_q;
    end else begin : g_io
      assign cap = SZ_W'(ADDR_W);
    end
    memsel_win #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_win (
      .addr_i(addr_i), .en_i(en_q[g]), .base_i(base_q[g]), .lsz_i(lsz_q[g]),
      .cap_i(cap), .hit_o(hit[g]), .off_o(off_r[g])
    );
  end

  logic [N_REG-1:0]  sel;
  logic              none;
  logic [ADDR_W-1:0] off_b;

  memsel_prio #(.ADDR_W(ADDR_W)) u_prio (
    .hit_i(hit), .off_i(off_r), .sel_o(sel), .none_o(none), .off_o(off_b)
  );

  assign code_cs_o  = sel[N_CODE-1:0];
  assign ram_cs_o   = sel[IDX_RAM];
  assign iio_cs_o   = sel[IDX_IIO];
  assign pio_cs_o   = sel[IDX_PIO];
  assign unmapped_o = none;
  assign offset_o   = bus16_q ? (off_b >> 1) : off_b;
  assign cfg_err_o  = err_q;
endmodule

// File: rtl/memsel_decoder_chk.sv
`timescale 1ns/1ps
module memsel_decoder_chk #(
  parameter int ADDR_W = 17,
  parameter int SZ_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus16_i,
  input logic [1:0]        blk_mode_i,
  input logic              ram_en_i,
  input logic [ADDR_W-1:0] ram_base_i,
  input logic [SZ_W-1:0]   ram_lsz_i,
  input logic              iio_en_i,
  input logic [ADDR_W-1:0] iio_base_i,
  input logic [SZ_W-1:0]   iio_lsz_i,
  input logic [3:0]        code_cs_o,
  input logic              ram_cs_o,
  input logic              iio_cs_o,
  input logic              pio_cs_o,
  input logic              unmapped_o,
  input logic [ADDR_W-1:0] offset_o,
  input logic              cfg_err_o
);
  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({code_cs_o, ram_cs_o, iio_cs_o, pio_cs_o}));

  p_unmapped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o == ({code_cs_o, ram_cs_o, iio_cs_o, pio_cs_o} == '0));

  p_unmapped_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (offset_o == '0));

  p_word_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus16_i |=> !offset_o[ADDR_W-1]);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  p_rsv_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_mode_i == 2'd3) |=> cfg_err_o);

  p_io_clash_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_i && iio_en_i && ram_base_i == iio_base_i && ram_lsz_i == iio_lsz_i) |=> cfg_err_o);
endmodule

bind memsel_decoder memsel_decoder_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus16_i(bus16_i), .blk_mode_i(blk_mode_i),
  .ram_en_i(ram_en_i), .ram_base_i(ram_base_i), .ram_lsz_i(ram_lsz_i),
  .iio_en_i(iio_en_i), .iio_base_i(iio_base_i), .iio_lsz_i(iio_lsz_i),
  .code_cs_o(code_cs_o), .ram_cs_o(ram_cs_o), .iio_cs_o(iio_cs_o), .pio_cs_o(pio_cs_o),
  .unmapped_o(unmapped_o), .offset_o(offset_o), .cfg_err_o(cfg_err_o)
);

// File: tb/memsel_decoder_tb.sv
`timescale 1ns/1ps
module memsel_decoder_tb;
  localparam int AW = 17;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic          wide = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [3:0]    ce = '0;
  logic [AW-1:0] cb [4];
  logic [SW-1:0] cl [4];
  logic re = 0, ie = 0, pe = 0;
  logic [AW-1:0] rb = '0, ib = '0, pb = '0;
  logic [SW-1:0] rl = '0, il = '0, pl = '0;

  logic [3:0]    code_cs;
  logic          ram_cs, iio_cs, pio_cs, unmapped, err;
  logic [AW-1:0] offset;

  memsel_decoder #(.ADDR_W(AW), .SZ_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .bus16_i(wide), .blk_mode_i(mode),
    .code_en_i(ce), .code_base_i({cb[3], cb[2], cb[1], cb[0]}),
    .code_lsz_i({cl[3], cl[2], cl[1], cl[0]}),
    .ram_en_i(re), .ram_base_i(rb), .ram_lsz_i(rl),
    .iio_en_i(ie), .iio_base_i(ib), .iio_lsz_i(il),
    .pio_en_i(pe), .pio_base_i(pb), .pio_lsz_i(pl),
    .code_cs_o(code_cs), .ram_cs_o(ram_cs), .iio_cs_o(iio_cs), .pio_cs_o(pio_cs),
    .unmapped_o(unmapped), .offset_o(offset), .cfg_err_o(err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  function automatic bit in_win(input int a, input int base, input int lsz);
    int sz, lo;
    if (lsz >= AW) return 1'b1;
    sz = 1 << lsz;
    lo = base - (base % sz);
    return (a >= lo) && (a < lo + sz);
  endfunction

  function automatic int modp(input int a, input int l);
    if (l >= AW) return a;
    return a % (1 << l);
  endfunction

  // Expected {code_cs, ram, iio, pio, unmapped, offset}
  function automatic logic [31:0] model(input int a);
    logic [3:0] c = '0;
    logic r = 0, i = 0, p = 0, u = 0;
    int off = 0;
    int blk = 13 + ((mode == 2'd3) ? 2 : int'(mode));
    if (re && in_win(a, rb, rl)) begin r = 1; off = modp(a, rl); end
    else if (ie && in_win(a, ib, il)) begin i = 1; off = modp(a, il); end
    else if (pe && in_win(a, pb, pl)) begin p = 1; off = modp(a, pl); end
    else begin
      u = 1;
      for (int k = 0; k < 4; k++) begin
        if (u && ce[k] && in_win(a, cb[k], cl[k])) begin
          c[k] = 1; u = 0;
          off = modp(a, (int'(cl[k]) < blk) ? int'(cl[k]) : blk);
        end
      end
    end
    if (wide) off = off >> 1;
    return {7'd0, c, r, i, p, u, AW'(off)};
  endfunction

  function automatic logic [31:0] actual();
    return {7'd0, code_cs, ram_cs, iio_cs, pio_cs, unmapped, offset};
  endfunction

  task automatic apply();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #10;
    rst_n = 1'b1;
    #1;
  endtask

  task automatic sweep(input string tag, input int step);
    for (int a = 0; a < (1 << AW); a += step) begin
      addr = AW'(a);
      #1;
      check(tag, actual(), model(a));
    end
  endtask

  task automatic cfg_b();
    wide = 0; mode = 2'd0; ce = 4'hF;
    for (int k = 0; k < 4; k++) begin cb[k] = AW'(k * 32'h2000); cl[k] = 5'd13; end
    re = 1; rb = 17'h01000; rl = 5'd11;
    ie = 1; ib = 17'h09000; il = 5'd8;
    pe = 0; pb = 17'h00000; pl = 5'd0;
  endtask

  initial begin
    #1_400_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin cb[k] = '0; cl[k] = '0; end
    #3;
    // R9 reset state: nothing mapped, no error
    check("R9 reset err", 32'(err), 32'd0);
    do_reset();
    addr = 17'h00000; #1; check("R9 reset map", actual(), {7'd0, 8'b0000_0001, 17'd0});
    addr = 17'h1ABCD; #1; check("R9 reset map", actual(), {7'd0, 8'b0000_0001, 17'd0});

    // R1 R3 R4 R5: 8 KB blocks, RAM and IIO inside code, byte mode
    cfg_b(); apply();
    check("R6 R7 R8 clean cfg", 32'(err), 32'd0);
    sweep("R1 R3 R4 R5 layout8k", 1);

    // R10: config change waits for the edge
    addr = 17'h01004; re = 0; #2;
    check("R10 before edge", actual(), {7'd0, 8'b0000_1000, 17'h00004});
    apply();
    check("R10 after edge", actual(), {7'd0, 8'b0001_0000, 17'h01004});

    // R2 R5: 32 KB blocks, narrower window, word mode
    do_reset();
    wide = 1; mode = 2'd2; ce = 4'hF;
    cb[0] = 17'h00000; cl[0] = 5'd15;
    cb[1] = 17'h08000; cl[1] = 5'd14;
    cb[2] = 17'h10000; cl[2] = 5'd15;
    cb[3] = 17'h18000; cl[3] = 5'd15;
    re = 1; rb = 17'h04000; rl = 5'd11;
    ie = 1; ib = 17'h10100; il = 5'd6;
    pe = 1; pb = 17'h1F000; pl = 5'd12;
    apply();
    check("R2 clean 32k", 32'(err), 32'd0);
    sweep("R2 R3 R5 layout32k_word", 1);

    // R1: full-space RAM window
    do_reset();
    cfg_b(); ie = 0; rl = 5'd17; apply();
    sweep("R1 full space", 97);

    // R11: disabled regions stacked on live ones are ignored
    do_reset();
    cfg_b(); ce = 4'b1101; cb[1] = 17'h00000; pe = 0; pb = 17'h09000; pl = 5'd8;
    apply();
    check("R11 no err", 32'(err), 32'd0);
    sweep("R11 disabled ignored", 7);

    // R6: code windows overlap
    do_reset();
    cfg_b(); cb[2] = 17'h03000; apply();
    check("R6 code overlap", 32'(err), 32'd1);

    // R7: peripheral I/O stacked on RAM
    do_reset();
    cfg_b(); pe = 1; pb = 17'h01400; pl = 5'd4; apply();
    check("R7 io overlap", 32'(err), 32'd1);

    // R8: 16 KB window on an 8 KB block, offset capped at block size
    do_reset();
    cfg_b(); ce = 4'b0001; cl[0] = 5'd14; re = 0; ie = 0; apply();
    check("R8 oversize", 32'(err), 32'd1);
    addr = 17'h03001; #1;
    check("R8 R5 capped offset", actual(), {7'd0, 8'b0001_0000, 17'h01001});
    sweep("R8 R5 oversize map", 13);

    // R2: reserved mode flags and decodes as 32 KB
    do_reset();
    cfg_b(); mode = 2'd3; ce = 4'b0001; cl[0] = 5'd15; re = 0; ie = 0; apply();
    check("R2 reserved err", 32'(err), 32'd1);
    addr = 17'h06002; #1;
    check("R2 reserved as 32k", actual(), {7'd0, 8'b0001_0000, 17'h06002});

    // R9: sticky after correction, cleared by reset
    cfg_b(); apply(); apply();
    check("R9 sticky", 32'(err), 32'd1);
    do_reset();
    check("R9 reset clears", 32'(err), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule